// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block passes data between an A side and a B side of a split data path. Each direction has a storage register. A per-direction select picks what that direction sends onto the far side: the live value arriving from the near side, or the value held in the register. Each direction also has its own output enable and its own capture input. The data path is divided into two independent halves, and each half has a full set of these controls. With this split the block works either as one wide transceiver, when both halves get the same controls, or as two narrow ones.

Pins that would be tri-state are modelled as three vectors per side: incoming data, outgoing data, and an output-enable mask. Registers are captured on a rising edge of a capture input, as sampled by the block clock. Capture does not depend on the select or enable levels, so a value can be stored while nothing is driven. When both directions of a half are enabled in live mode, each output repeats the other side's input. A value present on the two sides is then held by this loop and no register is involved.

Top module: `bus_xcvr_reg`

## Requirements
- R1: The data path is split into GROUPS halves of WIDTH/GROUPS bits. Half h covers bits [h*GW +: GW] and is governed only by control bit h of each control vector.
- R2: The A-to-B enable `oe_ab[h]` is active high. Out of reset, every bit of `b_oe` in half h is 1 when it is 1, and 0 when it is 0.
- R3: The B-to-A enable `oe_ba_n[h]` is active low. Out of reset, every bit of `a_oe` in half h is 1 when it is 0, and 0 when it is 1.
- R4: With half h enabled A-to-B, `b_out` carries `a_in` in the same cycle when `sel_ab[h]`=0 (live). It carries the A-to-B register when `sel_ab[h]`=1 (stored).
- R5: With half h enabled B-to-A, `a_out` carries `b_in` when `sel_ba[h]`=0 (live), and the B-to-A register when `sel_ba[h]`=1 (stored).
- R6: A clock edge at which `cap_ab[h]` is 1, after having been 0 at the previous edge, loads `a_in` of half h into the A-to-B register. This happens whatever the select and enable levels are, and a stored-mode output shows the new value right after that edge.
- R7: The same capture rule applies to `cap_ba[h]`, which loads `b_in` of half h into the B-to-A register.
- R8: Without such a rising capture, a register keeps its contents. This includes a capture input held high over many edges.
- R9: While `rst_n` is 0, `a_oe` and `b_oe` are all zero whatever the enables are, and both registers are cleared to zero. After reset, a capture needs the capture input to be seen low before it is seen high.
- R10: Wherever an output-enable bit is 0, the matching output data bit is 0.
- R11: With both directions of a half enabled and both selects live, `b_out` repeats `a_in` and `a_out` repeats `b_in`. A value on both sides is therefore re-driven on both and held, and neither register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; samples the capture inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| oe_ab | input | GROUPS | A-to-B enable per half, active high |
| oe_ba_n | input | GROUPS | B-to-A enable per half, active low |
| sel_ab | input | GROUPS | A-to-B source per half: 0 live, 1 stored |
| sel_ba | input | GROUPS | B-to-A source per half: 0 live, 1 stored |
| cap_ab | input | GROUPS | A-to-B capture input per half, rising-edge active |
| cap_ba | input | GROUPS | B-to-A capture input per half, rising-edge active |
| a_in | input | WIDTH | Data seen on the A side |
| b_in | input | WIDTH | Data seen on the B side |
| a_out | output | WIDTH | Data driven onto the A side |
| a_oe | output | WIDTH | Drive mask for the A side |
| b_out | output | WIDTH | Data driven onto the B side |
| b_oe | output | WIDTH | Drive mask for the B side |

## Verification
The bench builds the block with its defaults, WIDTH=16 and GROUPS=2. Two halves let the randomized controls reach every combination of select, enable and capture in one half while the other half is in an unrelated state, so cross-coupling between halves would show up. The 8-bit halves give enough distinct data values that a live path and a stored path almost never carry equal data by chance. Directed cases cover capture with both outputs disabled, a capture input held high, the reinforcing loop, and enables asserted during reset.

// File: rtl/bus_xcvr_pkg.sv
package bus_xcvr_pkg;

  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_sel_e;

  // A capture fires on a low-to-high change between two clock samples.
  function automatic logic rise_seen(input logic was, input logic now);
    return now & ~was;
  endfunction

endpackage

// File: rtl/xcvr_edge_store.sv
module xcvr_edge_store #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         evt
);
  import bus_xcvr_pkg::*;

  logic cap_q;

  assign evt = rise_seen(cap_q, cap);

  // cap_q resets high so a capture input held high through reset is not an edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= 1'b1;
      q     <= '0;
    end else begin
      cap_q <= cap;
      if (evt) q <= d;
    end
  end
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_ab,
  input  logic         en_ba,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic         cap_ab,
  input  logic         cap_ba,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe,
  output logic [W-1:0] stored_ab,
  output logic [W-1:0] stored_ba,
  output logic         ab_evt,
  output logic         ba_evt
);
  import bus_xcvr_pkg::*;

  // AND-OR selection: each bit is one source or the other, no decoded middle state.
  function automatic logic [W-1:0] pick(input logic [W-1:0] live,
                                        input logic [W-1:0] held,
                                        input src_sel_e    s);
    logic [W-1:0] m;
    m = {W{s == SRC_STORED}};
    return (live & ~m) | (held & m);
  endfunction

  function automatic logic [W-1:0] gate(input logic [W-1:0] v, input logic en);
    return v & {W{en}};
  endfunction

  logic [W-1:0] to_b, to_a;

  xcvr_edge_store #(.W(W)) u_reg_ab (
    .clk(clk), .rst_n(rst_n), .cap(cap_ab), .d(a_in), .q(stored_ab), .evt(ab_evt)
  );

  xcvr_edge_store #(.W(W)) u_reg_ba (
    .clk(clk), .rst_n(rst_n), .cap(cap_ba), .d(b_in), .q(stored_ba), .evt(ba_evt)
  );

  assign to_b  = pick(a_in, stored_ab, src_sel_e'(sel_ab));
  assign to_a  = pick(b_in, stored_ba, src_sel_e'(sel_ba));
  assign b_out = gate(to_b, en_ab);
  assign a_out = gate(to_a, en_ba);
  assign b_oe  = {W{en_ab}};
  assign a_oe  = {W{en_ba}};
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg #(
  parameter int WIDTH  = 16,
  parameter int GROUPS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GROUPS-1:0] oe_ab,
  input  logic [GROUPS-1:0] oe_ba_n,
  input  logic [GROUPS-1:0] sel_ab,
  input  logic [GROUPS-1:0] sel_ba,
  input  logic [GROUPS-1:0] cap_ab,
  input  logic [GROUPS-1:0] cap_ba,
  input  logic [WIDTH-1:0]  a_in,
  input  logic [WIDTH-1:0]  b_in,
  output logic [WIDTH-1:0]  a_out,
  output logic [WIDTH-1:0]  a_oe,
  output logic [WIDTH-1:0]  b_out,
  output logic [WIDTH-1:0]  b_oe
);
  localparam int GW = WIDTH / GROUPS;

  // Named internal events, brought out for the checker.
  logic [WIDTH-1:0]  stored_ab, stored_ba;
  logic [GROUPS-1:0] ab_cap_evt, ba_cap_evt;
  logic [GROUPS-1:0] en_ab, en_ba;

  // Reset overrides both enables (R9); polarity handled here (R2, R3).
  assign en_ab = oe_ab & {GROUPS{rst_n}};
  assign en_ba = ~oe_ba_n & {GROUPS{rst_n}};

  for (genvar g = 0; g < GROUPS; g++) begin : g_half
    xcvr_lane #(.W(GW)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_ab    (en_ab[g]),
      .en_ba    (en_ba[g]),
      .sel_ab   (sel_ab[g]),
      .sel_ba   (sel_ba[g]),
      .cap_ab   (cap_ab[g]),
      .cap_ba   (cap_ba[g]),
      .a_in     (a_in[g*GW +: GW]),
      .b_in     (b_in[g*GW +: GW]),
      .a_out    (a_out[g*GW +: GW]),
      .a_oe     (a_oe[g*GW +: GW]),
      .b_out    (b_out[g*GW +: GW]),
      .b_oe     (b_oe[g*GW +: GW]),
      .stored_ab(stored_ab[g*GW +: GW]),
      .stored_ba(stored_ba[g*GW +: GW]),
      .ab_evt   (ab_cap_evt[g]),
      .ba_evt   (ba_cap_evt[g])
    );
  end
endmodule

// File: rtl/bus_xcvr_reg_chk.sv
module bus_xcvr_reg_chk #(
  parameter int WIDTH  = 16,
  parameter int GROUPS = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [GROUPS-1:0] oe_ab,
  input logic [GROUPS-1:0] oe_ba_n,
  input logic [GROUPS-1:0] sel_ab,
  input logic [GROUPS-1:0] sel_ba,
  input logic [GROUPS-1:0] cap_ab,
  input logic [GROUPS-1:0] cap_ba,
  input logic [WIDTH-1:0]  a_in,
  input logic [WIDTH-1:0]  b_in,
  input logic [WIDTH-1:0]  a_out,
  input logic [WIDTH-1:0]  a_oe,
  input logic [WIDTH-1:0]  b_out,
  input logic [WIDTH-1:0]  b_oe,
  input logic [WIDTH-1:0]  stored_ab,
  input logic [WIDTH-1:0]  stored_ba,
  input logic [GROUPS-1:0] ab_cap_evt,
  input logic [GROUPS-1:0] ba_cap_evt
);
  localparam int GW = WIDTH / GROUPS;

  always_comb begin
    if (!rst_n) begin
      p_oe_off_in_reset_r9: assert (a_oe == '0 && b_oe == '0)
        else $error("enable active during reset");
    end
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_chk
    p_b_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
      b_oe[g*GW +: GW] == {GW{oe_ab[g]}});
    p_a_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
      a_oe[g*GW +: GW] == {GW{~oe_ba_n[g]}});
    p_b_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_ab[g] && !sel_ab[g]) |-> b_out[g*GW +: GW] == a_in[g*GW +: GW]);
    p_b_stored_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_ab[g] && sel_ab[g]) |-> b_out[g*GW +: GW] == stored_ab[g*GW +: GW]);
    p_a_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!oe_ba_n[g] && !sel_ba[g]) |-> a_out[g*GW +: GW] == b_in[g*GW +: GW]);
    p_a_stored_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!oe_ba_n[g] && sel_ba[g]) |-> a_out[g*GW +: GW] == stored_ba[g*GW +: GW]);
    p_ab_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ab_cap_evt[g] |=> stored_ab[g*GW +: GW] == $past(a_in[g*GW +: GW]));
    p_ab_evt_needs_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ab_cap_evt[g] |-> cap_ab[g]);
    p_ba_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ba_cap_evt[g] |=> stored_ba[g*GW +: GW] == $past(b_in[g*GW +: GW]));
    p_ba_evt_needs_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ba_cap_evt[g] |-> cap_ba[g]);
    p_ab_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !ab_cap_evt[g] |=> $stable(stored_ab[g*GW +: GW]));
    p_ba_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !ba_cap_evt[g] |=> $stable(stored_ba[g*GW +: GW]));
    p_b_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_ab[g] |-> b_out[g*GW +: GW] == '0);
    p_a_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      oe_ba_n[g] |-> a_out[g*GW +: GW] == '0);
  end
endmodule

bind bus_xcvr_reg bus_xcvr_reg_chk #(.WIDTH(WIDTH), .GROUPS(GROUPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .oe_ab(oe_ab), .oe_ba_n(oe_ba_n),
  .sel_ab(sel_ab), .sel_ba(sel_ba), .cap_ab(cap_ab), .cap_ba(cap_ba),
  .a_in(a_in), .b_in(b_in), .a_out(a_out), .a_oe(a_oe),
  .b_out(b_out), .b_oe(b_oe), .stored_ab(stored_ab), .stored_ba(stored_ba),
  .ab_cap_evt(ab_cap_evt), .ba_cap_evt(ba_cap_evt)
);

// File: tb/tb_bus_xcvr_reg.sv
module tb_bus_xcvr_reg;
  localparam int WIDTH  = 16;
  localparam int GROUPS = 2;
  localparam int GW     = WIDTH / GROUPS;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [GROUPS-1:0] oe_ab, oe_ba_n, sel_ab, sel_ba, cap_ab, cap_ba;
  logic [WIDTH-1:0]  a_in, b_in;
  logic [WIDTH-1:0]  a_out, a_oe, b_out, b_oe;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // Bench reference state.
  logic [WIDTH-1:0]  m_ab, m_ba;
  logic [GROUPS-1:0] m_last_ab, m_last_ba;

  always #2 clk = ~clk;

  bus_xcvr_reg #(.WIDTH(WIDTH), .GROUPS(GROUPS)) dut (
    .clk(clk), .rst_n(rst_n), .oe_ab(oe_ab), .oe_ba_n(oe_ba_n),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .cap_ab(cap_ab), .cap_ba(cap_ba),
    .a_in(a_in), .b_in(b_in), .a_out(a_out), .a_oe(a_oe),
    .b_out(b_out), .b_oe(b_oe)
  );

  function automatic logic [WIDTH-1:0] want_b_out();
    logic [WIDTH-1:0] r = '0;
    for (int h = 0; h < GROUPS; h++)
      if (rst_n && oe_ab[h])
        r[h*GW +: GW] = sel_ab[h] ? m_ab[h*GW +: GW] : a_in[h*GW +: GW];
    return r;
  endfunction

  function automatic logic [WIDTH-1:0] want_a_out();
    logic [WIDTH-1:0] r = '0;
    for (int h = 0; h < GROUPS; h++)
      if (rst_n && !oe_ba_n[h])
        r[h*GW +: GW] = sel_ba[h] ? m_ba[h*GW +: GW] : b_in[h*GW +: GW];
    return r;
  endfunction

  function automatic logic [WIDTH-1:0] want_b_oe();
    logic [WIDTH-1:0] r = '0;
    for (int h = 0; h < GROUPS; h++)
      if (rst_n && oe_ab[h]) r[h*GW +: GW] = '1;
    return r;
  endfunction

  function automatic logic [WIDTH-1:0] want_a_oe();
    logic [WIDTH-1:0] r = '0;
    for (int h = 0; h < GROUPS; h++)
      if (rst_n && !oe_ba_n[h]) r[h*GW +: GW] = '1;
    return r;
  endfunction

  task automatic check(input string req, input logic [WIDTH-1:0] act,
                       input logic [WIDTH-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called just after a falling edge with inputs applied; checks, then crosses one rising edge.
  task automatic step(input string tag);
    #1;
    check({tag, " R2/b_oe"},  b_oe,  want_b_oe());
    check({tag, " R3/a_oe"},  a_oe,  want_a_oe());
    check({tag, " R4/b_out"}, b_out, want_b_out());
    check({tag, " R5/a_out"}, a_out, want_a_out());
    @(posedge clk);
    if (!rst_n) begin
      m_ab = '0; m_ba = '0; m_last_ab = '1; m_last_ba = '1;
    end else begin
      for (int h = 0; h < GROUPS; h++) begin
        if (cap_ab[h] && !m_last_ab[h]) m_ab[h*GW +: GW] = a_in[h*GW +: GW];
        if (cap_ba[h] && !m_last_ba[h]) m_ba[h*GW +: GW] = b_in[h*GW +: GW];
      end
      m_last_ab = cap_ab;
      m_last_ba = cap_ba;
    end
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [WIDTH-1:0] v;
    void'($urandom(32'd20240611));
    m_ab = '0; m_ba = '0; m_last_ab = '1; m_last_ba = '1;
    rst_n = 1'b0;
    oe_ab = '1; oe_ba_n = '0; sel_ab = '0; sel_ba = '0;
    cap_ab = '0; cap_ba = '0; a_in = 16'hA5C3; b_in = 16'h3C5A;
    @(negedge clk);
    // R9: enables requested during reset must not drive.
    for (int i = 0; i < 3; i++) begin
      #1;
      check("R9 reset a_oe", a_oe, '0);
      check("R9 reset b_oe", b_oe, '0);
      check("R10 reset b_out", b_out, '0);
      step("R9 reset");
    end
    rst_n = 1'b1;
    // R9: registers read back as zero in stored mode.
    sel_ab = '1; sel_ba = '1;
    #1;
    check("R9 cleared A-to-B register", b_out, '0);
    check("R9 cleared B-to-A register", a_out, '0);
    step("R9 post-reset");

    // R6/R7: capture with both outputs disabled.
    oe_ab = '0; oe_ba_n = '1; a_in = 16'h1234; b_in = 16'h9876;
    cap_ab = '1; cap_ba = '1;
    #1;
    check("R10 disabled b_out", b_out, '0);
    check("R10 disabled a_out", a_out, '0);
    step("R6 capture while disabled");
    // R8: capture held high, new data must not load.
    a_in = 16'hFFFF; b_in = 16'h0000;
    step("R8 held high");
    step("R8 held high");
    oe_ab = '1; oe_ba_n = '0;
    #1;
    check("R6 stored A-to-B value", b_out, 16'h1234);
    check("R7 stored B-to-A value", a_out, 16'h9876);
    step("R8 readback");

    // R1: halves independent, only upper half captures.
    cap_ab = '0; cap_ba = '0;
    step("R1 drop capture");
    a_in = 16'hBEEF; cap_ab = 2'b10;
    step("R1 upper capture");
    #1;
    check("R1 split capture", b_out, 16'hBE34);
    sel_ab = 2'b01;
    #1;
    check("R1 split select", b_out, 16'hBE34 & 16'hFF00 | 16'h0034);
    step("R1 mixed select");

    // R11: both live and enabled, each side re-driven with the other's value.
    cap_ab = '0; cap_ba = '0; sel_ab = '0; sel_ba = '0;
    oe_ab = '1; oe_ba_n = '0;
    v = 16'h5AA5; a_in = v; b_in = v;
    #1;
    check("R11 loop b_out", b_out, v);
    check("R11 loop a_out", a_out, v);
    step("R11 loop");
    step("R11 loop");
    sel_ab = '1; sel_ba = '1;
    #1;
    check("R11 registers untouched A-to-B", b_out, 16'hBE34);
    check("R11 registers untouched B-to-A", a_out, 16'h9876);
    step("R11 readback");

    // Random phase across all select/enable/capture combinations.
    for (int i = 0; i < 4000; i++) begin
      oe_ab   = GROUPS'($urandom);
      oe_ba_n = GROUPS'($urandom);
      sel_ab  = GROUPS'($urandom);
      sel_ba  = GROUPS'($urandom);
      for (int h = 0; h < GROUPS; h++) begin
        if ($urandom % 3 == 0) cap_ab[h] = ~cap_ab[h];
        if ($urandom % 3 == 0) cap_ba[h] = ~cap_ba[h];
      end
      a_in = WIDTH'($urandom);
      b_in = WIDTH'($urandom);
      step("R1-rand R6 R7 R8 R10");
    end

    done = 1'b1;
    finish_run();
  end
endmodule